// File: doc/BRIEF.md
# Audio Serial Bit-Clock and Frame-Sync Generator

This block produces the master-mode timing for a synchronous audio serial port. It runs on the master clock and derives a bit clock with a 50% duty cycle from a chain of divide stages. An optional divide-by-8 prescale stage and an optional divide-by-2 stage feed a programmable modulus counter, and the bit clock toggles each time that counter reaches its terminal count. The same block counts bits within a word and words within a frame, and it drives a frame-sync output that changes only together with a rising bit-clock edge. It also exposes the running bit and word position, which the neighbouring shift registers use.

Two framing styles are available. In normal framing a word-length code and a word-count code set the frame geometry, and frame sync is a pulse one bit-clock long that marks the first bit of word 0. In I2S framing every slot is 32 bits and a frame always holds two slots, whatever the codes say. Frame sync then becomes a word-select level with a 50% duty cycle, and it switches one bit before the MSB of each slot. The configuration is captured only while the block is disabled. After enable, four full bit-clock cycles pass before framing begins.

Top module: `audio_frame_clkgen`

## Requirements
- R1: The bit clock has a 50% duty cycle, and its half period is (M+1)·D·P master-clock cycles. M is the modulus code, D is 2 when the divide-by-2 select is 1 (otherwise 1), and P is 8 when the prescale select is 1 (otherwise 1).
- R2: The prescale stage and the divide-by-2 stage combine with the modulus counter. Each one multiplies the half period independently of the other.
- R3: In normal framing a word holds 2·(W+1) bits, where W is the word-length code. The bit index counts from 0 to that count minus 1 and advances once per rising bit-clock edge.
- R4: In normal framing a frame holds C+1 words, where C is the word-count code. The word index advances when the bit index wraps, and it wraps after the last word.
- R5: In normal framing, frame sync is high for exactly one bit-clock period, while the bit index is 0 and the word index is 0. It repeats every (bits per word × words per frame) bit clocks.
- R6: When the I2S select is 1, slots are 32 bits and a frame holds 2 slots. Frame sync is low for word 0 bits 0 to 30 and for word 1 bit 31. It is high for the other 32 bits. Its first rise after enable falls on the 36th rising bit-clock edge.
- R7: Frame sync changes only in the master-clock cycle in which the bit clock rises.
- R8: After enable, frame sync stays low for the first 4 rising bit-clock edges. Normal framing begins on the 5th rising edge, which carries bit 0 of word 0.
- R9: The cycle after enable is sampled low, the bit clock, frame sync, bit index and word index are all 0. Configuration inputs are captured only while enable is low. Changes made while enabled have no effect.
- R10: While reset is high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low stops the block and opens configuration capture |
| cfg_div2 | input | 1 | Selects the extra divide-by-2 stage |
| cfg_pre8 | input | 1 | Selects the divide-by-8 prescale stage |
| cfg_modulus | input | MOD_W (8) | Modulus code M |
| cfg_wlen | input | WL_W (4) | Word-length code W |
| cfg_wcnt | input | DC_W (5) | Word-count code C |
| cfg_i2s | input | 1 | I2S framing select |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync pulse, or word-select level in I2S framing |
| bit_idx_o | output | BIT_W (5) | Bit position within the current word |
| word_idx_o | output | WORD_W (5) | Word position within the current frame |

## Verification
A rising bit-clock edge and a frame-sync edge must land in the same master-clock cycle. The bench looks at every frame-sync edge and checks that the bit clock rose in that same sample. A second collision occurs when the bit index and the word index both wrap on one edge: one-word frames and two-bit words force that wrap on every word. The bench judges these cases by the frame-sync high time and repeat period, by the largest bit and word indices seen, and by the rise count at the first frame sync.

// File: rtl/afg_pkg.sv
package afg_pkg;
  parameter int MOD_W = 8;
  parameter int WL_W  = 4;
  parameter int DC_W  = 5;
  parameter int I2S_SLOT = 32;

  localparam int SLOT_NRM = 2 ** (WL_W + 1);
  localparam int SLOT_MAX = (SLOT_NRM > I2S_SLOT) ? SLOT_NRM : I2S_SLOT;
  localparam int BIT_W    = $clog2(SLOT_MAX);
  localparam int WORD_W   = DC_W;
  localparam int BCNT_W   = BIT_W + 1;
  localparam int WCNT_W   = WORD_W + 1;

  typedef struct packed {
    logic              div2;
    logic              pre8;
    logic [MOD_W-1:0]  modulus;
    logic [WL_W-1:0]   wlen;
    logic [DC_W-1:0]   wcnt;
    logic              i2s;
  } afg_cfg_t;

  function automatic logic [BCNT_W-1:0] slot_bits(afg_cfg_t c);
    if (c.i2s) return BCNT_W'(I2S_SLOT);
    return BCNT_W'(2 * (int'(c.wlen) + 1));
  endfunction

  function automatic logic [WCNT_W-1:0] frame_words(afg_cfg_t c);
    if (c.i2s) return WCNT_W'(2);
    return WCNT_W'(int'(c.wcnt) + 1);
  endfunction
endpackage

// File: rtl/afg_div_stage.sv
module afg_div_stage #(
  parameter int RATIO = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic bypass,
  input  logic tick_i,
  output logic tick_o
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick_i && !bypass) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign tick_o = bypass ? tick_i : (tick_i && (cnt == LAST));

  AST_STAGE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!run) |=> (cnt == '0)) else $error("stage counter not cleared"); // R9
endmodule

// File: rtl/afg_bclk_gen.sv
module afg_bclk_gen
  import afg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick_i,
  input  logic [MOD_W-1:0] modulus,
  output logic             bclk_o,
  output logic             rise_o
);
  logic [MOD_W-1:0] cnt;
  logic             term;

  assign term   = run && tick_i && (cnt == modulus);
  assign rise_o = term && !bclk_o;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt    <= '0;
      bclk_o <= 1'b0;
    end else if (tick_i) begin
      if (cnt == modulus) begin
        cnt    <= '0;
        bclk_o <= ~bclk_o;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_MOD_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= modulus) else $error("modulus counter overran"); // R1
  AST_BCLK_OFF: assert property (@(posedge clk) disable iff (rst)
    (!run) |=> (!bclk_o)) else $error("bit clock running while off"); // R9
endmodule

// File: rtl/afg_frame_seq.sv
module afg_frame_seq
  import afg_pkg::*;
#(
  parameter int WARMUP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              rise_i,
  input  afg_cfg_t          cfg,
  output logic              fsync_o,
  output logic [BIT_W-1:0]  bit_idx_o,
  output logic [WORD_W-1:0] word_idx_o
);
  localparam int WMW = $clog2(WARMUP + 1);
  localparam logic [WMW-1:0] WARM_END = WMW'(WARMUP);

  logic [WMW-1:0]    warm;
  logic              framing;
  logic [BCNT_W-1:0] bw;
  logic [WCNT_W-1:0] nw;
  logic              bit_last, word_last;
  logic [BIT_W-1:0]  nbit;
  logic [WORD_W-1:0] nword;
  logic              fs_next;

  always_comb begin
    bw        = slot_bits(cfg);
    nw        = frame_words(cfg);
    bit_last  = (BCNT_W'(bit_idx_o) == bw - 1'b1);
    word_last = (WCNT_W'(word_idx_o) == nw - 1'b1);
    nbit      = bit_idx_o;
    nword     = word_idx_o;
    if (!framing) begin
      nbit  = '0;
      nword = '0;
    end else if (bit_last) begin
      nbit  = '0;
      nword = word_last ? '0 : word_idx_o + 1'b1;
    end else begin
      nbit  = bit_idx_o + 1'b1;
    end
    if (cfg.i2s) begin
      fs_next = ((nword == '0) && (BCNT_W'(nbit) == bw - 1'b1)) ||
                ((nword == WORD_W'(1)) && (BCNT_W'(nbit) != bw - 1'b1));
    end else begin
      fs_next = (nbit == '0) && (nword == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      warm       <= '0;
      framing    <= 1'b0;
      bit_idx_o  <= '0;
      word_idx_o <= '0;
      fsync_o    <= 1'b0;
    end else if (rise_i) begin
      if (warm != WARM_END) begin
        warm <= warm + 1'b1;
      end else begin
        framing    <= 1'b1;
        bit_idx_o  <= nbit;
        word_idx_o <= nword;
        fsync_o    <= fs_next;
      end
    end
  end

  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    BCNT_W'(bit_idx_o) < bw) else $error("bit index out of word"); // R3
  AST_WORD_RANGE: assert property (@(posedge clk) disable iff (rst)
    WCNT_W'(word_idx_o) < nw) else $error("word index out of frame"); // R4
  AST_FS_AT_START: assert property (@(posedge clk) disable iff (rst)
    (fsync_o && !cfg.i2s) |-> (bit_idx_o == '0 && word_idx_o == '0)) else $error("sync pulse off frame start"); // R5
  AST_I2S_WS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (cfg.i2s && framing && BCNT_W'(bit_idx_o) != bw - 1'b1) |-> (fsync_o == (word_idx_o == WORD_W'(1)))) else $error("word select wrong"); // R6
  AST_WARM_QUIET: assert property (@(posedge clk) disable iff (rst)
    (warm != WARM_END) |-> (!fsync_o && !framing)) else $error("sync during warm-up"); // R8
endmodule

// File: rtl/audio_frame_clkgen.sv
module audio_frame_clkgen
  import afg_pkg::*;
#(
  parameter int WARMUP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cfg_div2,
  input  logic              cfg_pre8,
  input  logic [MOD_W-1:0]  cfg_modulus,
  input  logic [WL_W-1:0]   cfg_wlen,
  input  logic [DC_W-1:0]   cfg_wcnt,
  input  logic              cfg_i2s,
  output logic              bclk_o,
  output logic              fsync_o,
  output logic [BIT_W-1:0]  bit_idx_o,
  output logic [WORD_W-1:0] word_idx_o
);
  localparam int NSTG = 2;

  afg_cfg_t        cfg_q;
  logic [NSTG:0]   tk;
  logic [NSTG-1:0] byp;
  logic            bclk_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (!en) begin
      cfg_q <= '{div2: cfg_div2, pre8: cfg_pre8, modulus: cfg_modulus,
                 wlen: cfg_wlen, wcnt: cfg_wcnt, i2s: cfg_i2s};
    end
  end

  assign tk[0] = 1'b1;
  assign byp   = {~cfg_q.div2, ~cfg_q.pre8};

  for (genvar gi = 0; gi < NSTG; gi++) begin : g_stage
    afg_div_stage #(.RATIO((gi == 0) ? 8 : 2)) u_stg (
      .clk    (clk),
      .rst    (rst),
      .run    (en),
      .bypass (byp[gi]),
      .tick_i (tk[gi]),
      .tick_o (tk[gi+1])
    );
  end

  afg_bclk_gen u_bclk (
    .clk     (clk),
    .rst     (rst),
    .run     (en),
    .tick_i  (tk[NSTG]),
    .modulus (cfg_q.modulus),
    .bclk_o  (bclk_o),
    .rise_o  (bclk_rise)
  );

  afg_frame_seq #(.WARMUP(WARMUP)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .run        (en),
    .rise_i     (bclk_rise),
    .cfg        (cfg_q),
    .fsync_o    (fsync_o),
    .bit_idx_o  (bit_idx_o),
    .word_idx_o (word_idx_o)
  );

  // port-level rise counter used only by the checks below
  logic       bclk_d;
  logic [3:0] rises_seen;
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      bclk_d     <= 1'b0;
      rises_seen <= '0;
    end else begin
      bclk_d <= bclk_o;
      if (bclk_o && !bclk_d && rises_seen != 4'hF) rises_seen <= rises_seen + 1'b1;
    end
  end

  AST_FS_ON_BCLK_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync_o) |-> $rose(bclk_o)) else $error("sync rose off bit-clock edge"); // R7
  AST_FS_FALL_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    ($fell(fsync_o) && en && $past(en)) |-> $rose(bclk_o)) else $error("sync fell off bit-clock edge"); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en)) |-> $stable(cfg_q)) else $error("config moved while enabled"); // R9
  AST_FIRST_FS_LATE: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync_o) |-> (rises_seen >= 4'(WARMUP))) else $error("sync too soon after enable"); // R8
endmodule

// File: tb/audio_frame_clkgen_tb.sv
module audio_frame_clkgen_tb;
  import afg_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic cfg_div2 = 1'b0, cfg_pre8 = 1'b0, cfg_i2s = 1'b0;
  logic [MOD_W-1:0] cfg_modulus = '0;
  logic [WL_W-1:0]  cfg_wlen = '0;
  logic [DC_W-1:0]  cfg_wcnt = '0;
  logic bclk_o, fsync_o;
  logic [BIT_W-1:0]  bit_idx_o;
  logic [WORD_W-1:0] word_idx_o;

  always #2 clk = ~clk;

  audio_frame_clkgen u_dut (
    .clk(clk), .rst(rst), .en(en), .cfg_div2(cfg_div2), .cfg_pre8(cfg_pre8),
    .cfg_modulus(cfg_modulus), .cfg_wlen(cfg_wlen), .cfg_wcnt(cfg_wcnt), .cfg_i2s(cfg_i2s),
    .bclk_o(bclk_o), .fsync_o(fsync_o), .bit_idx_o(bit_idx_o), .word_idx_o(word_idx_o)
  );

  localparam int NV = 8;
  // columns: div2, pre8, modulus, wlen, wcnt, i2s, half period, bits/word, words/frame
  localparam int V_DIV2[NV] = '{0, 0, 1, 0, 1, 0, 0, 0};
  localparam int V_PRE8[NV] = '{0, 0, 0, 1, 1, 0, 0, 0};
  localparam int V_MOD [NV] = '{1, 23, 2, 0, 1, 0, 2, 0};
  localparam int V_WL  [NV] = '{3, 7, 1, 0, 2, 5, 15, 0};
  localparam int V_DC  [NV] = '{3, 3, 2, 1, 0, 3, 31, 0};
  localparam int V_I2S [NV] = '{0, 0, 0, 0, 0, 1, 0, 0};
  localparam int V_HALF[NV] = '{2, 24, 6, 8, 32, 1, 3, 1};
  localparam int V_BW  [NV] = '{8, 16, 4, 2, 6, 32, 32, 2};
  localparam int V_NW  [NV] = '{4, 4, 3, 2, 1, 2, 32, 1};

  int n_chk = 0;
  int n_bad = 0;
  int wd = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", wd);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic run_vec(input int v, input bit perturb);
    int cyc = 0, nrise = 0, last_rise = -1, per = -1, high = -1;
    int fs_n = 0, fs_first = -1, fs_last = -1, fs_per = -1, fs_high = -1;
    int off_edge = 0, start_bad = 0, max_bit = 0, max_word = 0;
    int h, bw, nw, frame, limit, first_exp;
    logic pb = 1'b0, pf = 1'b0;
    h = V_HALF[v]; bw = V_BW[v]; nw = V_NW[v];
    frame = 2 * h * bw * nw;
    limit = 4 * frame + 80 * h + 200;
    first_exp = (V_I2S[v] != 0) ? 36 : 5;
    @(negedge clk);
    en = 1'b0;
    cfg_div2 = V_DIV2[v][0]; cfg_pre8 = V_PRE8[v][0]; cfg_i2s = V_I2S[v][0];
    cfg_modulus = MOD_W'(V_MOD[v]); cfg_wlen = WL_W'(V_WL[v]); cfg_wcnt = DC_W'(V_DC[v]);
    repeat (3) @(negedge clk);
    en = 1'b1;
    while (fs_n < 3 && cyc < limit) begin
      @(posedge clk); #1;
      cyc++;
      if (perturb && cyc == 10) begin
        cfg_modulus = MOD_W'(9); cfg_wlen = '0; cfg_wcnt = '0; cfg_div2 = 1'b1;
      end
      if (bclk_o && !pb) begin
        nrise++;
        if (last_rise >= 0) per = cyc - last_rise;
        last_rise = cyc;
      end
      if (!bclk_o && pb && last_rise >= 0) high = cyc - last_rise;
      if (fsync_o != pf && !(bclk_o && !pb)) off_edge++;
      if (fsync_o && !pf) begin
        fs_n++;
        if (fs_first < 0) fs_first = nrise;
        if (fs_last >= 0) fs_per = cyc - fs_last;
        fs_last = cyc;
        if (V_I2S[v] == 0 && (bit_idx_o != 0 || word_idx_o != 0)) start_bad++;
      end
      if (!fsync_o && pf && fs_last >= 0) fs_high = cyc - fs_last;
      if (int'(bit_idx_o) > max_bit) max_bit = int'(bit_idx_o);
      if (int'(word_idx_o) > max_word) max_word = int'(word_idx_o);
      pb = bclk_o; pf = fsync_o;
    end
    $display("vector %0d perturb %0d", v, perturb);
    chk(perturb ? "R9" : "R1", "bclk period", per, 2 * h);
    chk("R1", "bclk high time", high, h);
    if (V_DIV2[v] != 0 || V_PRE8[v] != 0) chk("R2", "chained half period", per / 2, h);
    chk("R7", "sync edges off bclk rise", off_edge, 0);
    chk(V_I2S[v] != 0 ? "R6" : "R8", "rise count at first sync", fs_first, first_exp);
    chk(V_I2S[v] != 0 ? "R6" : "R5", "sync repeat", fs_per, frame);
    chk(V_I2S[v] != 0 ? "R6" : "R5", "sync high time", fs_high, (V_I2S[v] != 0) ? 64 * h : 2 * h);
    chk("R3", "largest bit index", max_bit, bw - 1);
    chk("R4", "largest word index", max_word, nw - 1);
    if (V_I2S[v] == 0) chk("R5", "sync away from bit0 word0", start_bad, 0);
    // disable: everything back to zero the next cycle (R9)
    @(negedge clk);
    en = 1'b0;
    @(posedge clk); #1;
    chk("R9", "outputs after disable", int'({bclk_o, fsync_o, bit_idx_o, word_idx_o}), 0);
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "outputs in reset", int'({bclk_o, fsync_o, bit_idx_o, word_idx_o}), 0);
    @(negedge clk);
    en = 1'b1;
    @(posedge clk); #1;
    chk("R10", "outputs in reset with enable", int'({bclk_o, fsync_o, bit_idx_o, word_idx_o}), 0);
    @(negedge clk);
    en = 1'b0;
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R10", "outputs after reset release", int'({bclk_o, fsync_o, bit_idx_o, word_idx_o}), 0);

    for (int v = 0; v < NV; v++) run_vec(v, 1'b0);

    // R9: configuration changed while running must not take effect
    run_vec(0, 1'b1);

    // R8: no sync during the first four rising edges at the fastest setting
    begin
      int r8_rises = 0;
      int r8_fs = 0;
      logic p = 1'b0;
      @(negedge clk);
      cfg_div2 = 1'b0; cfg_pre8 = 1'b0; cfg_i2s = 1'b0;
      cfg_modulus = '0; cfg_wlen = '0; cfg_wcnt = '0;
      repeat (2) @(negedge clk);
      en = 1'b1;
      while (r8_rises < 4) begin
        @(posedge clk); #1;
        if (bclk_o && !p) r8_rises++;
        if (fsync_o && r8_rises < 5) r8_fs++;
        p = bclk_o;
      end
      @(posedge clk); #1;
      chk("R8", "sync seen during warm-up", r8_fs + int'(fsync_o), 0);
      @(posedge clk); #1;
      chk("R8", "sync on fifth rise", int'(fsync_o && bclk_o), 1);
      @(negedge clk);
      en = 1'b0;
    end

    repeat (4) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule